// File: doc/BRIEF.md
# Ratio-Preserving Activity Profile Counters

The block keeps four activity counters that together describe how a channel is used: cycles spent transmitting, cycles spent receiving, cycles the medium was sensed busy, and the total number of counted clock cycles. The busy, transmit and receive qualifiers come from logic outside the block. Software divides one counter by another to get a utilisation figure, so the ratios between the counters matter more than their absolute values.

None of the counters ever wraps. When a counter that already holds all ones is due to increment, the whole group is halved in the same cycle by a one-bit right shift. Pending increments are then added on top of the halved values. The ratios therefore stay consistent, with at most one count of rounding. A freeze input stops all counting. A clear input zeroes the group. Any counter can be read at any time through a select and a data port, and a read never disturbs the count. The block raises no interrupt.

Top module: `prof_ratio_counters`

## Requirements
- R1: After reset every counter reads zero.
- R2: The cycle counter (select code 3) gains one on every clock edge where freeze is low and clear is low.
- R3: The transmit (select code 0), receive (select code 1) and busy (select code 2) counters each gain one on a clock edge where freeze is low, clear is low and their own activity input is high. They are unchanged when that input is low.
- R4: While freeze is high and clear is low, no counter changes and no halving occurs, whatever the activity inputs do.
- R5: Clear set high at a clock edge zeroes all four counters. It takes priority over freeze, increments and halving.
- R6: When any counter holds all ones and is due to increment, all four counters are shifted right by one bit in that cycle. The counter that was full then reads a one in the top bit and zeros elsewhere, so no counter ever wraps.
- R7: In a halving cycle, every other counter takes its own value shifted right by one, plus one if its activity input is high in that cycle.
- R8: The read data port shows the counter chosen by the 2-bit select (0 transmit, 1 receive, 2 busy, 3 cycle) combinationally. Reading never alters any count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freeze | input | 1 | Holds every counter while high |
| clear | input | 1 | Zeroes every counter at the clock edge |
| tx_act | input | 1 | Transmit activity qualifier |
| rx_act | input | 1 | Receive activity qualifier |
| busy_act | input | 1 | Medium-busy qualifier |
| rd_sel | input | 2 | Counter select: 0 transmit, 1 receive, 2 busy, 3 cycle |
| rd_data | output | CNT_W | Value of the selected counter |

## Verification
The properties assume that the qualifiers and controls are synchronous to clk and hold steady around the sampling edge. They also assume the counters start from a cleared or reset state, so the cycle counter is never below another counter. Under that assumption the cycle counter is always the one that reaches all ones first. The stimulus changes every input only on the falling edge and always clears before a measured run. It uses a narrow counter width so the halving boundary is reached in a few hundred cycles. Each measured run ends by raising freeze, and reads are taken only while frozen, so expected values are exact.

// File: rtl/prof_pkg.sv
package prof_pkg;
    localparam int NUM_CNT = 4;
    localparam int SEL_W   = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_TX    = 2'd0,
        SEL_RX    = 2'd1,
        SEL_BUSY  = 2'd2,
        SEL_CYCLE = 2'd3
    } prof_sel_e;
endpackage

// File: rtl/prof_sat_detect.sv
module prof_sat_detect #(
    parameter int CNT_W = 32,
    parameter int N     = 4
) (
    input  logic [N-1:0][CNT_W-1:0] cnt_q,
    input  logic [N-1:0]            inc,
    output logic                    halve
);
    localparam logic [CNT_W-1:0] FULL = '1;

    logic [N-1:0] hit;

    for (genvar i = 0; i < N; i++) begin : g_hit
        assign hit[i] = inc[i] && (cnt_q[i] == FULL);
    end

    assign halve = |hit;
endmodule

// File: rtl/prof_lane_next.sv
module prof_lane_next #(
    parameter int CNT_W = 32
) (
    input  logic [CNT_W-1:0] cur_q,
    input  logic             inc,
    input  logic             halve,
    output logic [CNT_W-1:0] step_d
);
    logic [CNT_W-1:0] base;

    always_comb begin
        base   = halve ? (cur_q >> 1) : cur_q;
        step_d = base + CNT_W'(inc);
    end
endmodule

// File: rtl/prof_read_mux.sv
module prof_read_mux
    import prof_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q,
    input  logic [SEL_W-1:0]              sel,
    output logic [CNT_W-1:0]              data
);
    always_comb begin
        unique case (prof_sel_e'(sel))
            SEL_TX:    data = cnt_q[0];
            SEL_RX:    data = cnt_q[1];
            SEL_BUSY:  data = cnt_q[2];
            SEL_CYCLE: data = cnt_q[3];
            default:   data = '0;
        endcase
    end
endmodule

// File: rtl/prof_ratio_counters.sv
module prof_ratio_counters
    import prof_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             freeze,
    input  logic             clear,
    input  logic             tx_act,
    input  logic             rx_act,
    input  logic             busy_act,
    input  logic [1:0]       rd_sel,
    output logic [CNT_W-1:0] rd_data
);
    typedef struct packed {
        logic [NUM_CNT-1:0][CNT_W-1:0] cnt;
    } prof_state_t;

    prof_state_t state_d, state_q;

    logic [NUM_CNT-1:0]            inc;
    logic [NUM_CNT-1:0][CNT_W-1:0] step;
    logic                          halve;

    // Lane order: 0 transmit, 1 receive, 2 busy, 3 cycle (every enabled clock)
    assign inc = freeze ? '0 : {1'b1, busy_act, rx_act, tx_act};

    prof_sat_detect #(.CNT_W(CNT_W), .N(NUM_CNT)) u_sat (
        .cnt_q (state_q.cnt),
        .inc   (inc),
        .halve (halve)
    );

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_lane
        prof_lane_next #(.CNT_W(CNT_W)) u_lane (
            .cur_q  (state_q.cnt[i]),
            .inc    (inc[i]),
            .halve  (halve),
            .step_d (step[i])
        );
    end

    always_comb begin
        state_d = state_q;
        if (clear) begin
            state_d.cnt = '0;
        end else if (!freeze) begin
            state_d.cnt = step;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    prof_read_mux #(.CNT_W(CNT_W)) u_rd (
        .cnt_q (state_q.cnt),
        .sel   (rd_sel),
        .data  (rd_data)
    );
endmodule

// File: rtl/prof_ratio_counters_chk.sv
module prof_ratio_counters_chk #(
    parameter int CNT_W = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   freeze,
    input logic                   clear,
    input logic [1:0]             rd_sel,
    input logic [CNT_W-1:0]       rd_data,
    input logic [3:0][CNT_W-1:0]  cnt
);
    localparam logic [CNT_W-1:0] FULL = '1;
    localparam logic [CNT_W-1:0] TOP  = {1'b1, {(CNT_W-1){1'b0}}};

    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt == '0));

    assert_freeze_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !clear) |=> $stable(cnt));

    assert_cycle_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze && !clear && cnt[3] != FULL) |=> (cnt[3] == $past(cnt[3]) + 1'b1));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze && !clear && cnt[3] == FULL) |=> (cnt[3] == TOP));

    assert_read_view_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data == cnt[rd_sel]);
endmodule

bind prof_ratio_counters prof_ratio_counters_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .freeze  (freeze),
    .clear   (clear),
    .rd_sel  (rd_sel),
    .rd_data (rd_data),
    .cnt     (state_q.cnt)
);

// File: tb/tb_prof_ratio_counters.sv
`timescale 1ns/1ps
module tb_prof_ratio_counters;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         freeze = 1'b1;
    logic         clear = 1'b0;
    logic         tx_act = 1'b0;
    logic         rx_act = 1'b0;
    logic         busy_act = 1'b0;
    logic [1:0]   rd_sel = 2'd0;
    logic [W-1:0] rd_data;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    prof_ratio_counters #(.CNT_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .freeze(freeze), .clear(clear),
        .tx_act(tx_act), .rx_act(rx_act), .busy_act(busy_act),
        .rd_sel(rd_sel), .rd_data(rd_data)
    );

    task automatic check(input string req, input int sel, input int exp);
        rd_sel = sel[1:0];
        #1;
        checks++;
        if (int'(rd_data) != exp) begin
            fails++;
            $display("FAIL %s sel=%0d actual=%0d expected=%0d", req, sel, rd_data, exp);
        end
    endtask

    task automatic check_all(input string req, input int t, input int r, input int b, input int c);
        check(req, 0, t);
        check(req, 1, r);
        check(req, 2, b);
        check(req, 3, c);
    endtask

    task automatic do_clear();
        @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
    endtask

    task automatic run(input int n, input logic t, input logic r, input logic b);
        freeze = 1'b0; tx_act = t; rx_act = r; busy_act = b;
        repeat (n) @(negedge clk);
        freeze = 1'b1; tx_act = 1'b0; rx_act = 1'b0; busy_act = 1'b0;
    endtask

    task automatic t_reset();
        check_all("R1", 0, 0, 0, 0);
    endtask

    task automatic t_counting();
        do_clear();
        run(10, 1, 0, 0);
        run(6, 0, 1, 0);
        run(3, 1, 1, 1);
        check_all("R3", 13, 9, 3, 19);
        check("R2", 3, 19);
        check_all("R8", 13, 9, 3, 19);
    endtask

    task automatic t_freeze();
        @(negedge clk);
        freeze = 1'b1; tx_act = 1'b1; rx_act = 1'b1; busy_act = 1'b1;
        repeat (5) @(negedge clk);
        tx_act = 1'b0; rx_act = 1'b0; busy_act = 1'b0;
        check_all("R4", 13, 9, 3, 19);
    endtask

    task automatic t_clear();
        @(negedge clk);
        freeze = 1'b0; tx_act = 1'b1; rx_act = 1'b1; clear = 1'b1;
        @(negedge clk);
        clear = 1'b0; freeze = 1'b1; tx_act = 1'b0; rx_act = 1'b0;
        check_all("R5", 0, 0, 0, 0);
        run(4, 1, 0, 1);
        @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        check_all("R5", 0, 0, 0, 0);
    endtask

    task automatic t_halving();
        do_clear();
        run(100, 1, 1, 0);
        run(155, 1, 0, 0);
        check_all("R3", 255, 100, 0, 255);
        run(1, 1, 0, 1);
        check("R6", 0, 128);
        check("R6", 3, 128);
        check("R7", 1, 50);
        check("R7", 2, 1);
        run(2, 1, 1, 0);
        check_all("R6", 130, 52, 1, 130);
    endtask

    initial begin
        #5000000;
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_counting();
        t_freeze();
        t_clear();
        t_halving();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule